// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the device-side front end of a 16-bit multiplexed address/data bus. It sits in front of a small buffer RAM and a handful of control registers. One shared bus carries the address first and then the data. The bus is split at the block edge into an input word, an output word and an output-enable, so that the pad ring can build the tri-state driver. The interrupt line is split the same way.

Bus strobes are sampled on the bus clock. In asynchronous mode, the address is taken when the active-low address-valid strobe returns high. In burst mode, the address is taken on the first clock at which that strobe is low. A burst then streams successive words after a programmable latency, and a ready output marks each valid word. Write data is taken when the active-low write strobe returns high. A write to the command register starts a command timer. When the timer ends, the block sets a done flag, and that flag drives the interrupt output. The interrupt output is driven only when the pin-enable bit of the configuration register is set.

Top module: `muxbus_slave`

## Requirements
- R1: In asynchronous mode, the address is the bus value sampled in the last clock in which `avd_ni` was low, and it is taken at the first clock at which `avd_ni` is seen high again.
- R2: A write takes place at the first clock at which `we_ni` is seen high after being low. It stores the bus value from the last low cycle at the current address. Addresses 0 to BUF_DEPTH-1 are buffer RAM, 0xF000 is configuration, 0xF001 is command and 0xF002 is status.
- R3: `ad_oe_o` is high exactly when `ce_ni` and `oe_ni` are both low. `ad_o` carries the word at the current address. An unmapped address reads 0.
- R4: While `ce_ni` is high, `ad_oe_o` and `rdy_o` are low, a burst in progress ends, and strobes on `avd_ni` and `we_ni` change no state.
- R5: In the configuration register, bit 0 selects burst mode, bit 1 enables the interrupt pin and bits [4:2] hold the burst latency. The register resets to 0x0010: asynchronous mode, pin disabled, latency 4.
- R6: In burst mode, the address is the bus value at the first clock at which `avd_ni` is low after being high.
- R7: After a burst capture, `rdy_o` stays low for the number of clocks given by the latency field. It then goes high, and the current address advances by one on every further clock, so that `ad_o` streams consecutive words.
- R8: A write to 0xF001 sets busy and sets done CMD_CYCLES clocks after the write. Status bit 0 is done and bit 1 is busy. Writing the status register with bit 0 equal to 0 clears done.
- R9: `int_oe_o` equals the pin-enable bit, whatever the state of `ce_ni` and `oe_ni`. `int_o` equals the done flag.
- R10: A low level on `rst_ni` clears the buffer RAM, the registers, the command timer and any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, used for strobe sampling and burst timing |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| avd_ni | input | 1 | Address-valid strobe, active low |
| ad_i | input | 16 | Bus value seen at the pads |
| ad_o | output | 16 | Word to drive onto the bus |
| ad_oe_o | output | 1 | Bus driver enable |
| rdy_o | output | 1 | Burst data valid |
| int_o | output | 1 | Interrupt level (command done) |
| int_oe_o | output | 1 | Interrupt pin driver enable |

## Verification
The assertions assume that the host keeps `ad_i` stable for at least one clock while a strobe is low and that it never lowers both strobes in the same clock. They also assume that `avd_ni` is low for a single clock in burst mode and that the latency field is not rewritten in the middle of a burst. The bench drives every input on the falling clock edge and holds each strobe low for exactly one clock. It changes configuration only between bursts and deselects the block to end a burst, so every sampled value is settled before the edge that consumes it.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int BUS_W = 16;

  localparam logic [BUS_W-1:0] CFG_ADDR  = 16'hF000;
  localparam logic [BUS_W-1:0] CMD_ADDR  = 16'hF001;
  localparam logic [BUS_W-1:0] STAT_ADDR = 16'hF002;

  // configuration field positions
  localparam int CFG_SYNC_BIT = 0;
  localparam int CFG_PIN_BIT  = 1;
  localparam int CFG_LAT_LSB  = 2;
endpackage

// File: rtl/muxbus_strobe.sv
module muxbus_strobe
  import muxbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             avd_ni,
  input  logic             we_ni,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_q_o,
  output logic             avd_rise_o,
  output logic             avd_first_low_o,
  output logic             we_rise_o
);
  logic avd_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avd_q  <= 1'b1;
      we_q   <= 1'b1;
      ad_q_o <= '0;
    end else begin
      avd_q  <= avd_ni;
      we_q   <= we_ni;
      ad_q_o <= ad_i;
    end
  end

  assign avd_rise_o      = !ce_ni &&  avd_ni && !avd_q;
  assign avd_first_low_o = !ce_ni && !avd_ni &&  avd_q;
  assign we_rise_o       = !ce_ni &&  we_ni  && !we_q;

  a_r2_write_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_rise_o |-> !$past(we_ni));
  a_r4_no_edge_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !(avd_rise_o || avd_first_low_o || we_rise_o));
endmodule

// File: rtl/muxbus_addr.sv
module muxbus_addr
  import muxbus_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             sync_mode_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             avd_rise_i,
  input  logic             avd_first_low_i,
  input  logic [BUS_W-1:0] ad_i,
  input  logic [BUS_W-1:0] ad_q_i,
  output logic [BUS_W-1:0] addr_o,
  output logic             valid_o
);
  logic             active_q;
  logic [LAT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      active_q <= 1'b0;
      wait_q   <= '0;
    end else if (!sync_mode_i) begin
      active_q <= 1'b0;
      if (avd_rise_i) addr_o <= ad_q_i;
    end else if (avd_first_low_i) begin
      addr_o   <= ad_i;
      active_q <= 1'b1;
      wait_q   <= lat_i;
    end else if (ce_ni) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      else              addr_o <= addr_o + 1'b1;
    end
  end

  assign valid_o = active_q && (wait_q == '0);

  a_r1_async_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && avd_rise_i) |=> addr_o == $past(ad_q_i));
  a_r6_burst_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && avd_first_low_i) |=> addr_o == $past(ad_i));
  a_r7_latency_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && avd_first_low_i && lat_i != '0) |=> !valid_o);
  a_r7_address_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && valid_o && !ce_ni && !avd_first_low_i) |=> addr_o == $past(addr_o) + 1'b1);
  a_r4_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !valid_o);
endmodule

// File: rtl/muxbus_regs.sv
module muxbus_regs
  import muxbus_pkg::*;
#(
  parameter int BUF_AW     = 4,
  parameter int LAT_W      = 3,
  parameter int LAT_RST    = 4,
  parameter int CMD_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic [BUS_W-1:0] rd_addr_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             sync_mode_o,
  output logic             pin_en_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             done_o
);
  localparam int BUF_DEPTH = 1 << BUF_AW;
  localparam int CMD_W     = $clog2(CMD_CYCLES + 1);
  localparam int CFG_PAD   = BUS_W - LAT_W - 2;

  logic [BUS_W-1:0] mem_q [BUF_DEPTH];
  logic [BUS_W-1:0] cmd_q;
  logic             busy_q;
  logic [CMD_W-1:0] cmd_cnt_q;

  logic wr_buf, rd_buf;
  assign wr_buf = (wr_addr_i[BUS_W-1:BUF_AW] == '0);
  assign rd_buf = (rd_addr_i[BUS_W-1:BUF_AW] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i && wr_buf) begin
      mem_q[wr_addr_i[BUF_AW-1:0]] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_mode_o <= 1'b0;
      pin_en_o    <= 1'b0;
      lat_o       <= LAT_W'(LAT_RST);
      cmd_q       <= '0;
    end else if (wr_en_i && wr_addr_i == CFG_ADDR) begin
      sync_mode_o <= wr_data_i[CFG_SYNC_BIT];
      pin_en_o    <= wr_data_i[CFG_PIN_BIT];
      lat_o       <= wr_data_i[CFG_LAT_LSB +: LAT_W];
    end else if (wr_en_i && wr_addr_i == CMD_ADDR) begin
      cmd_q <= wr_data_i;
    end
  end

  // command timer and completion flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cmd_cnt_q <= '0;
      done_o    <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == CMD_ADDR && !busy_q) begin
        busy_q    <= 1'b1;
        cmd_cnt_q <= CMD_W'(CMD_CYCLES - 1);
      end else if (busy_q) begin
        if (cmd_cnt_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cmd_cnt_q <= cmd_cnt_q - 1'b1;
        end
      end
      if (wr_en_i && wr_addr_i == STAT_ADDR && !wr_data_i[0]) done_o <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_buf) rd_data_o = mem_q[rd_addr_i[BUF_AW-1:0]];
    else if (rd_addr_i == CFG_ADDR)  rd_data_o = {{CFG_PAD{1'b0}}, lat_o, pin_en_o, sync_mode_o};
    else if (rd_addr_i == CMD_ADDR)  rd_data_o = cmd_q;
    else if (rd_addr_i == STAT_ADDR) rd_data_o = {{(BUS_W-2){1'b0}}, busy_q, done_o};
  end

  a_r2_buffer_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_buf) |=> mem_q[$past(wr_addr_i[BUF_AW-1:0])] == $past(wr_data_i));
  a_r8_done_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_q));
  a_r9_pin_en_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pin_en_o));
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int BUF_AW     = 4,
  parameter int LAT_W      = 3,
  parameter int LAT_RST    = 4,
  parameter int CMD_CYCLES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic        avd_ni,
  input  logic [15:0] ad_i,
  output logic [15:0] ad_o,
  output logic        ad_oe_o,
  output logic        rdy_o,
  output logic        int_o,
  output logic        int_oe_o
);
  logic [BUS_W-1:0] ad_q, addr;
  logic             avd_rise, avd_first_low, we_rise;
  logic             sync_mode, pin_en, done, valid;
  logic [LAT_W-1:0] lat;

  muxbus_strobe u_strobe (
    .clk_i, .rst_ni, .ce_ni, .avd_ni, .we_ni, .ad_i,
    .ad_q_o          (ad_q),
    .avd_rise_o      (avd_rise),
    .avd_first_low_o (avd_first_low),
    .we_rise_o       (we_rise)
  );

  muxbus_addr #(.LAT_W(LAT_W)) u_addr (
    .clk_i, .rst_ni, .ce_ni,
    .sync_mode_i     (sync_mode),
    .lat_i           (lat),
    .avd_rise_i      (avd_rise),
    .avd_first_low_i (avd_first_low),
    .ad_i,
    .ad_q_i          (ad_q),
    .addr_o          (addr),
    .valid_o         (valid)
  );

  muxbus_regs #(
    .BUF_AW(BUF_AW), .LAT_W(LAT_W), .LAT_RST(LAT_RST), .CMD_CYCLES(CMD_CYCLES)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i     (we_rise),
    .wr_addr_i   (addr),
    .wr_data_i   (ad_q),
    .rd_addr_i   (addr),
    .rd_data_o   (ad_o),
    .sync_mode_o (sync_mode),
    .pin_en_o    (pin_en),
    .lat_o       (lat),
    .done_o      (done)
  );

  assign ad_oe_o  = !ce_ni && !oe_ni;
  assign rdy_o    = valid && !ce_ni;
  assign int_o    = done;
  assign int_oe_o = pin_en;

  a_r9_pin_independent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(ce_ni) || $changed(oe_ni)) && !we_rise |=> $stable(int_oe_o));
endmodule

// File: tb/muxbus_slave_test.sv
module muxbus_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_CYCLES = 8;
  localparam logic [15:0] CFG  = 16'hF000;
  localparam logic [15:0] CMD  = 16'hF001;
  localparam logic [15:0] STAT = 16'hF002;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, avd_ni = 1'b1;
  logic [15:0] ad_i = '0, ad_o;
  logic ad_oe_o, rdy_o, int_o, int_oe_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_slave #(.CMD_CYCLES(CMD_CYCLES)) uut (
    .clk_i(clk), .rst_ni, .ce_ni, .oe_ni, .we_ni, .avd_ni, .ad_i,
    .ad_o, .ad_oe_o, .rdy_o, .int_o, .int_oe_o
  );

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h1357) ^ 16'hA5A5);
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic async_addr(input logic [15:0] a);
    ce_ni = 1'b0; ad_i = a; avd_ni = 1'b0;
    @(negedge clk); avd_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic sync_addr(input logic [15:0] a);
    ce_ni = 1'b0; ad_i = a; avd_ni = 1'b0;
    @(negedge clk); avd_ni = 1'b1;
  endtask

  task automatic wr_data(input logic [15:0] d);
    ad_i = d; we_ni = 1'b0;
    @(negedge clk); we_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_now(output logic [15:0] d);
    oe_ni = 1'b0; #1;
    d = ad_o;
    check({15'b0, ad_oe_o}, 16'd1, "R3 output enable while reading");
    @(negedge clk); oe_ni = 1'b1;
  endtask

  task automatic burst(input logic [15:0] a, input int lat, input int n);
    sync_addr(a);
    check({15'b0, rdy_o}, 16'd0, "R7 ready low at capture");
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      check({15'b0, rdy_o}, 16'd0, "R7 ready low in latency");
    end
    oe_ni = 1'b0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check({15'b0, rdy_o}, 16'd1, "R7 ready high on data");
      check(ad_o, pat(int'(a) + j), "R6 R7 burst word");
    end
    check({15'b0, ad_oe_o}, 16'd1, "R3 burst drive");
    ce_ni = 1'b1; #1;
    check({14'b0, rdy_o, ad_oe_o}, 16'd0, "R4 deselect drops ready and drive");
    oe_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    check({13'b0, ad_oe_o, rdy_o, int_oe_o}, 16'd0, "R10 outputs after reset");
    async_addr(CFG); rd_now(d);
    check(d, 16'h0010, "R5 R10 config reset value");

    // R1 R2 R3 sweep over whole buffer
    for (int i = 0; i < 16; i++) begin
      async_addr(16'(i)); wr_data(pat(i));
    end
    for (int i = 15; i >= 0; i--) begin
      async_addr(16'(i)); rd_now(d);
      check(d, pat(i), "R1 R2 R3 buffer readback");
    end
    async_addr(16'h0123); rd_now(d);
    check(d, 16'h0000, "R3 unmapped reads zero");
    ce_ni = 1'b0; oe_ni = 1'b1; #1;
    check({15'b0, ad_oe_o}, 16'd0, "R3 no drive with output enable high");

    // R4: strobes ignored while deselected
    async_addr(16'd5);
    ce_ni = 1'b1; @(negedge clk);
    ad_i = 16'hDEAD; we_ni = 1'b0; @(negedge clk); we_ni = 1'b1; @(negedge clk);
    ad_i = 16'd7; avd_ni = 1'b0; @(negedge clk); avd_ni = 1'b1; @(negedge clk);
    #1;
    check({15'b0, ad_oe_o}, 16'd0, "R4 no drive deselected");
    ce_ni = 1'b0; @(negedge clk);
    rd_now(d);
    check(d, pat(5), "R4 write and address ignored while deselected");

    // R5 R6 R7 burst, latency 4
    async_addr(CFG); wr_data(16'h0011);
    burst(16'd3, 4, 6);
    // latency 2 written in burst mode
    sync_addr(CFG); wr_data(16'h0009);
    ce_ni = 1'b1; @(negedge clk);
    burst(16'd9, 2, 5);
    // back to asynchronous mode
    sync_addr(CFG); wr_data(16'h0010);
    ce_ni = 1'b1; @(negedge clk);
    async_addr(16'd2); rd_now(d);
    check(d, pat(2), "R5 asynchronous mode restored");

    // R8 R9 command completion and interrupt pin
    check({15'b0, int_oe_o}, 16'd0, "R9 pin released when disabled");
    async_addr(CFG); wr_data(16'h0012);
    check({14'b0, int_oe_o, int_o}, 16'b10, "R9 pin driven, no interrupt");
    async_addr(CMD); wr_data(16'h00C3);
    for (int k = 1; k < CMD_CYCLES; k++) @(negedge clk);
    check({15'b0, int_o}, 16'd0, "R8 not done one clock early");
    @(negedge clk);
    check({15'b0, int_o}, 16'd1, "R8 done after command time");
    ce_ni = 1'b1; oe_ni = 1'b1; @(negedge clk);
    check({14'b0, int_oe_o, int_o}, 16'b11, "R9 pin driven while deselected");
    async_addr(STAT); rd_now(d);
    check(d, 16'h0001, "R8 status shows done");
    async_addr(CMD); rd_now(d);
    check(d, 16'h00C3, "R2 command register holds write");
    async_addr(STAT); wr_data(16'h0000);
    check({15'b0, int_o}, 16'd0, "R8 R9 done cleared");

    // R10 reset mid run
    rst_ni = 1'b0; ce_ni = 1'b1; @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    check({15'b0, int_oe_o}, 16'd0, "R10 pin enable cleared");
    async_addr(16'd4); rd_now(d);
    check(d, 16'h0000, "R10 buffer cleared");
    async_addr(CFG); rd_now(d);
    check(d, 16'h0010, "R10 config restored");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule